// File: doc/BRIEF.md
# Pipelined Binary-Tree Longest-Prefix Lookup

This block finds the longest stored prefix that matches a destination address. The prefixes are held as a complete binary search tree. Each prefix is widened to the full address width by setting its unused low bits to one. The tree is ordered on the widened value, with the prefix length breaking ties. Each tree level lives in the private memory of one pipeline stage. A lookup visits one node per stage. It moves to the left or right child on a magnitude compare. When a node matches, the search records it and keeps going down, so that a longer match deeper in the tree can still replace it.

A new address may enter on every clock cycle, and there are no stalls. The answer comes out a fixed number of cycles later. It gives the tree position of the winning node, the length of that node's prefix and a found flag. Software builds the sorted tree and loads it through a write port that names a level and a slot. Writes go through that port while lookups keep streaming through the read side.

Top module: `bst_lpm_pipe`

## Requirements
- R1: `out_valid` rises exactly LEVELS+1 clock edges after the edge that samples `lk_valid` high. Back-to-back lookups, one per cycle, come out in issue order with no gaps.
- R2: A node with stored length L matches when the top L bits of the address equal the top L bits of the stored padded prefix. L may range from 0 to AW. L = 0 matches every address, and L = AW needs all bits to be equal.
- R3: After a hit, the search continues to the deeper levels. A later matching node with a strictly greater length replaces the recorded best, so the result is the longest match along the path.
- R4: At slot j of level k, the search goes to slot 2j of level k+1 when the address is less than or equal to the padded prefix. Otherwise it goes to slot 2j+1. An unused node sends the search to slot 2j.
- R5: A hit reports `out_found`=1 and `out_idx` = 2^k + j for the winning node at level k, slot j, so the root is 1. It also reports `out_len` = the stored length. A miss reports found=0, idx=0 and len=0. When `out_valid` is low, `out_found` is 0.
- R6: A slot whose used bit is 0 never matches.
- R7: A pulse on `wr_en` stores `wr_prefix`, `wr_len` and `wr_used` at slot `wr_slot` of level `wr_level`. A write whose slot is 2^`wr_level` or more is ignored. A lookup issued after the write cycle sees the new contents.
- R8: After reset, `out_valid` is low and every slot is unused, so any lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | A lookup enters this cycle |
| lk_addr | input | AW | Destination address to look up |
| wr_en | input | 1 | Write one tree slot |
| wr_level | input | max(1,clog2(LEVELS)) | Tree level of the write |
| wr_slot | input | max(1,LEVELS-1) | Slot within that level |
| wr_prefix | input | AW | Padded prefix to store |
| wr_len | input | clog2(AW+1) | Prefix length to store |
| wr_used | input | 1 | 1 marks the slot as holding a node |
| out_valid | output | 1 | Result present |
| out_found | output | 1 | A matching prefix was found |
| out_idx | output | IW | Tree position 2^k + j of the best match |
| out_len | output | clog2(AW+1) | Length of the best match |

## Verification
The bench builds the block with AW=8, LEVELS=4 and IW=5. This gives four stages and a tree of eight prefixes, with one node in the partly filled last level. Every search path is short enough to trace by hand, so each expected index and length is worked out from the requirements alone. The 8-bit address lets a full-length prefix and a zero-length default route sit in the same small tree. Either one can be reached by a chosen address.

// File: rtl/bst_lpm_pipe.sv
module bst_lpm_pipe #(
  parameter int AW     = 32,
  parameter int LEVELS = 4,
  parameter int IW     = 8,
  localparam int LW  = $clog2(AW + 1),
  localparam int LVW = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int OW  = (LEVELS > 1) ? LEVELS - 1 : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lk_valid,
  input  logic [AW-1:0] lk_addr,
  input  logic          wr_en,
  input  logic [LVW-1:0] wr_level,
  input  logic [OW-1:0] wr_slot,
  input  logic [AW-1:0] wr_prefix,
  input  logic [LW-1:0] wr_len,
  input  logic          wr_used,
  output logic          out_valid,
  output logic          out_found,
  output logic [IW-1:0] out_idx,
  output logic [LW-1:0] out_len
);

  logic          c_v [LEVELS+1];
  logic          c_f [LEVELS+1];
  logic [IW-1:0] c_i [LEVELS+1];
  logic [LW-1:0] c_l [LEVELS+1];
  logic [AW-1:0] c_a [LEVELS];
  logic [OW-1:0] c_o [LEVELS];

  assign c_v[0] = lk_valid;
  assign c_a[0] = lk_addr;
  assign c_o[0] = '0;
  assign c_f[0] = 1'b0;
  assign c_i[0] = '0;
  assign c_l[0] = '0;

  for (genvar k = 0; k < LEVELS; k++) begin : g_stage
    localparam int SW    = (k > 0) ? k : 1;
    localparam int SLOTS = 1 << SW;

    logic [AW-1:0]    pmem [SLOTS];
    logic [LW-1:0]    lmem [SLOTS];
    logic [SLOTS-1:0] used;

    logic          s_v, s_f, r_u;
    logic [AW-1:0] s_a, r_p;
    logic [OW-1:0] s_o;
    logic [IW-1:0] s_i;
    logic [LW-1:0] s_l, r_l;

    wire [SW-1:0] ws   = wr_slot[SW-1:0];
    wire [SW-1:0] rs   = c_o[k][SW-1:0];
    wire          wsel = wr_en && (wr_level == LVW'(k)) &&
                         ({1'b0, wr_slot} < (OW+1)'(1 << k));

    always_ff @(posedge clk) begin
      if (wsel) begin
        pmem[ws] <= wr_prefix;
        lmem[ws] <= wr_len;
      end
      r_p <= pmem[rs];
      r_l <= lmem[rs];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        used <= '0;
        r_u  <= 1'b0;
        s_v  <= 1'b0;
        s_a  <= '0;
        s_o  <= '0;
        s_f  <= 1'b0;
        s_i  <= '0;
        s_l  <= '0;
      end else begin
        if (wsel) used[ws] <= wr_used;
        r_u <= used[rs];
        s_v <= c_v[k];
        s_a <= c_a[k];
        s_o <= c_o[k];
        s_f <= c_f[k];
        s_i <= c_i[k];
        s_l <= c_l[k];
      end
    end

    wire [AW-1:0] mask = ~({AW{1'b1}} >> r_l);
    wire          hit  = r_u && (((s_a ^ r_p) & mask) == '0);
    wire          take = hit && (!s_f || r_l > s_l);

    assign c_v[k+1] = s_v;
    assign c_f[k+1] = s_f | take;
    assign c_i[k+1] = take ? IW'((1 << k) + int'(s_o)) : s_i;
    assign c_l[k+1] = take ? r_l : s_l;

    if (k < LEVELS - 1) begin : g_fwd
      wire go_r = r_u && (s_a > r_p);
      assign c_a[k+1] = s_a;
      assign c_o[k+1] = OW'({s_o, go_r});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_found <= 1'b0;
      out_idx   <= '0;
      out_len   <= '0;
    end else begin
      out_valid <= c_v[LEVELS];
      out_found <= c_v[LEVELS] && c_f[LEVELS];
      out_idx   <= c_f[LEVELS] ? c_i[LEVELS] : '0;
      out_len   <= c_f[LEVELS] ? c_l[LEVELS] : '0;
    end
  end

endmodule

// File: rtl/bst_lpm_pipe_chk.sv
module bst_lpm_pipe_chk #(
  parameter int AW     = 32,
  parameter int LEVELS = 4,
  parameter int IW     = 8,
  localparam int LW = $clog2(AW + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lk_valid,
  input logic          out_valid,
  input logic          out_found,
  input logic [IW-1:0] out_idx,
  input logic [LW-1:0] out_len
);

  logic [LEVELS:0] vsh;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vsh <= '0;
    else        vsh <= {vsh[LEVELS-1:0], lk_valid};
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vsh[LEVELS]); // R1
  AST_IDLE_NO_FOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_found); // R5
  AST_MISS_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_found) |-> (out_idx == '0 && out_len == '0)); // R5
  AST_IDX_IN_TREE: assert property (@(posedge clk) disable iff (!rst_n)
    out_found |-> (out_idx != '0 && int'(out_idx) < (1 << LEVELS))); // R5
  AST_LEN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    out_found |-> int'(out_len) <= AW); // R2

endmodule

bind bst_lpm_pipe bst_lpm_pipe_chk #(.AW(AW), .LEVELS(LEVELS), .IW(IW)) chk_i (.*);

// File: tb/bst_lpm_pipe_tb_top.sv
`timescale 1ns/1ps
module bst_lpm_pipe_tb_top;
  localparam int AW = 8, LEVELS = 4, IW = 5;
  localparam int LW = $clog2(AW + 1);
  localparam int LAT = LEVELS + 1;
  localparam int NV = 9;
  // {addr, idx, len, found}
  localparam logic [17:0] VEC [NV] = '{
    {8'h4A, 5'd4, 4'd3, 1'b1}, {8'h20, 5'd8, 4'd2, 1'b1},
    {8'h85, 5'd5, 4'd4, 1'b1}, {8'hB0, 5'd1, 4'd2, 1'b1},
    {8'hD5, 5'd6, 4'd3, 1'b1}, {8'hF3, 5'd7, 4'd0, 1'b1},
    {8'hE9, 5'd3, 4'd4, 1'b1}, {8'h60, 5'd2, 4'd1, 1'b1},
    {8'hC0, 5'd6, 4'd3, 1'b1}};

  logic clk = 0, rst_n = 0, lk_valid = 0, wr_en = 0, wr_used = 0;
  logic [AW-1:0] lk_addr = '0, wr_prefix = '0;
  logic [1:0] wr_level = '0;
  logic [2:0] wr_slot = '0;
  logic [LW-1:0] wr_len = '0;
  logic out_valid, out_found;
  logic [IW-1:0] out_idx;
  logic [LW-1:0] out_len;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  bst_lpm_pipe #(.AW(AW), .LEVELS(LEVELS), .IW(IW)) dut_i (.*);

  task automatic check_res(string req, logic [IW-1:0] ei, logic [LW-1:0] el, logic ef);
    checks++;
    if (out_valid !== 1'b1 || out_found !== ef || out_idx !== ei || out_len !== el) begin
      errors++;
      $display("FAIL %s: got v=%0b f=%0b idx=%0d len=%0d, expected v=1 f=%0b idx=%0d len=%0d",
               req, out_valid, out_found, out_idx, out_len, ef, ei, el);
    end
  endtask

  task automatic lookup(string req, logic [AW-1:0] a, logic [IW-1:0] ei, logic [LW-1:0] el, logic ef);
    @(negedge clk); lk_valid = 1; lk_addr = a;
    @(negedge clk); lk_valid = 0;
    repeat (LAT - 1) @(negedge clk);
    check_res(req, ei, el, ef);
  endtask

  task automatic wr(int lv, int sl, logic [AW-1:0] p, int ln, logic u);
    @(negedge clk);
    wr_en = 1; wr_level = 2'(lv); wr_slot = 3'(sl); wr_prefix = p; wr_len = LW'(ln); wr_used = u;
    @(negedge clk); wr_en = 0;
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 0 || out_found !== 0) begin
      errors++; $display("FAIL R8: got v=%0b f=%0b, expected 0 0", out_valid, out_found);
    end
    rst_n = 1;
    lookup("R8 empty table", 8'h4A, 0, 0, 0);

    wr(0, 0, 8'hBF, 2, 1); wr(1, 0, 8'h7F, 1, 1); wr(1, 1, 8'hEF, 4, 1);
    wr(2, 0, 8'h5F, 3, 1); wr(2, 1, 8'h8F, 4, 1); wr(2, 2, 8'hDF, 3, 1);
    wr(2, 3, 8'hFF, 0, 1); wr(3, 0, 8'h3F, 2, 1);

    // R1 R2 R3 R4 R5: streamed table, one lookup per cycle
    for (int t = 0; t < NV + LAT; t++) begin
      @(negedge clk);
      if (t >= LAT) check_res("R1/R3 stream", VEC[t-LAT][9:5], VEC[t-LAT][4:1], VEC[t-LAT][0]);
      else begin
        checks++;
        if (out_valid !== 0) begin
          errors++; $display("FAIL R1: got early v=%0b, expected 0", out_valid);
        end
      end
      lk_valid = (t < NV);
      if (t < NV) lk_addr = VEC[t][17:10];
    end
    lk_valid = 0;

    // R2: full-length prefix in last level
    wr(3, 1, 8'h60, 8, 1);
    lookup("R2 full length hit", 8'h60, 9, 8, 1);
    lookup("R2 one bit off", 8'h61, 2, 1, 1);
    // R6: unused slot never matches
    wr(2, 3, 8'hFF, 0, 0);
    lookup("R6 unused default", 8'hF3, 0, 0, 0);
    wr(2, 3, 8'hFF, 0, 1);
    lookup("R7 rewrite visible", 8'hF3, 7, 0, 1);
    // R7: out-of-range slot write ignored
    wr(0, 1, 8'h00, 0, 1);
    lookup("R7 out of range ignored", 8'hB0, 1, 2, 1);
    // R8: reset clears slots
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    checks++;
    if (out_valid !== 0) begin
      errors++; $display("FAIL R8: got v=%0b, expected 0", out_valid);
    end
    rst_n = 1;
    lookup("R8 reset clears table", 8'h4A, 0, 0, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule